// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block runs one step of an 8-bit asynchronous NAND flash transaction for a processor that programs it through a small register port. Software first loads a column address, a row address, a data word, a timing word and an address-size word, then writes a control word with its launch bit set. The control word chooses which of the phases run: a first command byte, a special single address byte or the column and row address bytes, a second command byte followed by a long wait, and one to four data bytes read from or written to the flash.

The engine drives chip enable, command latch, address latch, write strobe, read strobe and the data bus, and samples the flash's ready/busy line through a synchronizer. Strobe, setup and hold widths come from the timing word as clock counts. A hold bit in the control word leaves chip enable asserted once the step ends, so that a full flash transaction can be stitched together from several control writes. Software polls the launch bit, which stays set while the engine works.

Top module: `nand_seq`

## Requirements
- R1: After reset the engine is idle (status bit 31 clear), chip enable, write strobe and read strobe are high, command and address latch are low, the data bus is not driven, and status bit 26 reads 1 while the ready/busy input is high.
- R2: A register write to select 0 with bit 31 set while idle launches a step; status bit 31 reads 1 from the next cycle until every selected phase has finished, and a launch that selects no phase finishes with no strobe.
- R3: Control bit 16 issues one command byte from control bits 7:0 and control bit 19 issues one command byte from control bits 15:8; each is one write strobe with command latch high and address latch low.
- R4: Control bit 17 issues column bytes from the column register (select 1) and bit 18 issues row bytes from the row register (select 2); the counts are config (select 5) bits 5:4 plus one and bits 7:6 plus one, sent least-significant byte first, each one write strobe with address latch high.
- R5: Control bit 24 sends exactly one address byte of 0x00 and suppresses the column and row bytes.
- R6: Phases run in the order: first command, address bytes, second command, long wait, data.
- R7: Control bit 21 (with bit 20 clear) writes control bits 29:28 plus one data bytes from the data register (select 3), byte k taken from bits 8k+7:8k, each one write strobe with both latches low.
- R8: Control bit 20 (with bit 21 clear) reads control bits 29:28 plus one bytes, byte k stored into data register bits 8k+7:8k while the other bytes keep their value; the engine never drives the bus while the read strobe is low.
- R9: Chip enable is low while busy; at the end of a step it stays low if control bit 30 was set and returns high if it was clear.
- R10: A control write while busy is ignored: the running step and the control fields read back in status bits 30:0 are unchanged.
- R11: The timing word (select 4) holds write-strobe low width at bits 5:0, read-strobe low width at 11:6, setup at 17:12, hold at 23:18 and long wait at 29:24, in clock cycles, a field of 0 acting as 1; write and read strobes never overlap.
- R12: When control bit 19 is set, busy lasts at least hold plus long-wait cycles after the rising edge of the second command's write strobe.
- R13: Status bit 26 follows the ready/busy input two clock edges after it changes; status bit 27 is set by a launch that selects both read and write, in which case no data cycle runs, and cleared by the next launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 control, 1 column, 2 row, 3 data, 4 timing, 5 config |
| reg_wdata | input | 32 | Register write data |
| stat_rdata | output | 32 | Control readback with busy (31), error (27) and ready (26) |
| data_rdata | output | 32 | Data register readback |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Data bus out |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_i | input | 8 | Data bus in |
| nand_rb_n | input | 1 | Ready/busy from the flash, low while busy |

## Verification
A wrong phase or byte counter inside the engine shows up on the very next write strobe as a missing, extra or misplaced latch byte, so the bench logs every strobe's latch levels and bus value and compares the whole sequence against one built from the control and config words, sweeping all sixteen column/row byte-count pairs and all data counts. A wrong sub-phase count shows as a strobe of the wrong width in the same cycle it ends, and a missed long wait shows as busy dropping a few cycles after the last command strobe instead of after the wait. Read packing errors appear in the data readback as soon as the step finishes, and a stale chip-enable decision shows on the pin in the cycle busy falls.

// File: rtl/nand_seq_pkg.sv
// Shared types and helpers for the NAND command sequencer.
package nand_seq_pkg;

    // Phases in the order they run; numeric order is the run order.
    typedef enum logic [3:0] {
        PH_IDLE = 4'd0,
        PH_CMDA = 4'd1,
        PH_SPEC = 4'd2,
        PH_COLA = 4'd3,
        PH_ROWA = 4'd4,
        PH_CMDB = 4'd5,
        PH_WAIT = 4'd6,
        PH_DATA = 4'd7,
        PH_DONE = 4'd8
    } phase_e;

    // Parts of one byte cycle.
    typedef enum logic [1:0] {
        SB_SETUP = 2'd0,
        SB_LOW   = 2'd1,
        SB_HOLD  = 2'd2
    } sub_e;

    localparam logic [2:0] SEL_CTRL = 3'd0;
    localparam logic [2:0] SEL_COL  = 3'd1;
    localparam logic [2:0] SEL_ROW  = 3'd2;
    localparam logic [2:0] SEL_DATA = 3'd3;
    localparam logic [2:0] SEL_TIME = 3'd4;
    localparam logic [2:0] SEL_CFG  = 3'd5;

    localparam int B_GO   = 31;
    localparam int B_HOLD = 30;
    localparam int B_CMDA = 16;
    localparam int B_COLA = 17;
    localparam int B_ROWA = 18;
    localparam int B_CMDB = 19;
    localparam int B_RD   = 20;
    localparam int B_WR   = 21;
    localparam int B_SPEC = 24;

    // Whether a phase is selected by a control word.
    function automatic logic phase_on(phase_e p, logic [31:0] c);
        case (p)
            PH_CMDA: return c[B_CMDA];
            PH_SPEC: return c[B_SPEC];
            PH_COLA: return c[B_COLA] && !c[B_SPEC];
            PH_ROWA: return c[B_ROWA] && !c[B_SPEC];
            PH_CMDB: return c[B_CMDB];
            PH_WAIT: return c[B_CMDB];
            PH_DATA: return c[B_RD] ^ c[B_WR];
            PH_DONE: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // First selected phase after the given one.
    function automatic phase_e next_phase(phase_e cur, logic [31:0] c);
        phase_e r;
        r = PH_DONE;
        for (int i = 8; i >= 1; i--) begin
            if (i > int'(cur) && phase_on(phase_e'(4'(i)), c)) r = phase_e'(4'(i));
        end
        return r;
    endfunction

endpackage

// File: rtl/nand_sync.sv
// Multi-flop synchronizer for an asynchronous level input.
// Assumes the input is a slow level; resets to the inactive-high value.
module nand_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/nand_timer.sv
// Down counter that times one sub-phase.
// A load sets the remaining count; expired is high when it has reached zero.
module nand_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    // Load or count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/nand_seq.sv
// NAND flash command sequencer.
// Runs the phases a control word selects, in fixed order, on an 8-bit
// asynchronous NAND bus. Assumes software leaves the address, data and
// timing registers alone while busy.
module nand_seq
    import nand_seq_pkg::*;
#(
    parameter int TIME_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] stat_rdata,
    output logic [31:0] data_rdata,
    output logic        nand_ce_n,
    output logic        nand_cle,
    output logic        nand_ale,
    output logic        nand_we_n,
    output logic        nand_re_n,
    output logic [7:0]  nand_dq_o,
    output logic        nand_dq_oe,
    input  logic [7:0]  nand_dq_i,
    input  logic        nand_rb_n
);
    localparam int F_WE = 0;
    localparam int F_RE = TIME_W;
    localparam int F_SU = 2 * TIME_W;
    localparam int F_HD = 3 * TIME_W;
    localparam int F_LW = 4 * TIME_W;

    logic [31:0] ctrl_q, col_q, row_q, data_q, time_q;
    logic [7:0]  cfg_q;
    logic        busy_q, err_q, ce_n_q, ready_s;
    phase_e      ph_q, ph_d, np;
    sub_e        sub_q, sub_d;
    logic [1:0]  bidx_q, bidx_d, last_idx;
    logic        t_load, t_done, cap, launch, rd_phase, drv_phase;
    logic [TIME_W-1:0] t_val;
    logic [7:0]  cur_byte;

    // Load value for a width field: a zero field behaves as one cycle.
    function automatic logic [TIME_W-1:0] ld(logic [TIME_W-1:0] f);
        return (f == '0) ? '0 : f - 1'b1;
    endfunction

    nand_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(nand_rb_n), .dout(ready_s)
    );

    nand_timer #(.W(TIME_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expired(t_done)
    );

    assign launch = reg_we && (reg_sel == SEL_CTRL) && reg_wdata[B_GO] && !busy_q;

    // Per-phase byte count and byte value.
    always_comb begin
        last_idx = 2'd0;
        cur_byte = 8'h00;
        case (ph_q)
            PH_CMDA: cur_byte = ctrl_q[7:0];
            PH_COLA: begin last_idx = cfg_q[5:4]; cur_byte = col_q[{bidx_q, 3'b000} +: 8]; end
            PH_ROWA: begin last_idx = cfg_q[7:6]; cur_byte = row_q[{bidx_q, 3'b000} +: 8]; end
            PH_CMDB: cur_byte = ctrl_q[15:8];
            PH_DATA: begin last_idx = ctrl_q[29:28]; cur_byte = data_q[{bidx_q, 3'b000} +: 8]; end
            default: ;
        endcase
    end

    assign rd_phase  = (ph_q == PH_DATA) && ctrl_q[B_RD];
    assign drv_phase = (ph_q inside {PH_CMDA, PH_SPEC, PH_COLA, PH_ROWA, PH_CMDB})
                    || ((ph_q == PH_DATA) && !ctrl_q[B_RD]);
    assign np = next_phase(ph_q, ctrl_q);

    // Next phase, sub-phase, byte index and timer load.
    always_comb begin
        ph_d   = ph_q;
        sub_d  = sub_q;
        bidx_d = bidx_q;
        t_load = 1'b0;
        t_val  = '0;
        cap    = 1'b0;
        if (launch) begin
            ph_d   = next_phase(PH_IDLE, reg_wdata);
            sub_d  = SB_SETUP;
            bidx_d = 2'd0;
            t_load = 1'b1;
            t_val  = ld(time_q[F_SU +: TIME_W]);
        end else if (busy_q && ph_q == PH_DONE) begin
            ph_d = PH_IDLE;
        end else if (busy_q && t_done) begin
            if (ph_q == PH_WAIT || (sub_q == SB_HOLD && bidx_q == last_idx)) begin
                ph_d   = np;
                sub_d  = SB_SETUP;
                bidx_d = 2'd0;
                t_load = 1'b1;
                t_val  = (np == PH_WAIT) ? ld(time_q[F_LW +: TIME_W]) : ld(time_q[F_SU +: TIME_W]);
            end else begin
                t_load = 1'b1;
                case (sub_q)
                    SB_SETUP: begin
                        sub_d = SB_LOW;
                        t_val = rd_phase ? ld(time_q[F_RE +: TIME_W]) : ld(time_q[F_WE +: TIME_W]);
                    end
                    SB_LOW: begin
                        sub_d = SB_HOLD;
                        t_val = ld(time_q[F_HD +: TIME_W]);
                        cap   = rd_phase;
                    end
                    default: begin
                        sub_d  = SB_SETUP;
                        bidx_d = bidx_q + 2'd1;
                        t_val  = ld(time_q[F_SU +: TIME_W]);
                    end
                endcase
            end
        end
    end

    // Register file, launch, completion and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0; col_q <= '0; row_q <= '0; data_q <= '0;
            time_q <= '0; cfg_q <= '0;
            busy_q <= 1'b0; err_q <= 1'b0; ce_n_q <= 1'b1;
            ph_q <= PH_IDLE; sub_q <= SB_SETUP; bidx_q <= 2'd0;
        end else begin
            if (reg_we) begin
                case (reg_sel)
                    SEL_COL:  col_q  <= reg_wdata;
                    SEL_ROW:  row_q  <= reg_wdata;
                    SEL_DATA: data_q <= reg_wdata;
                    SEL_TIME: time_q <= reg_wdata;
                    SEL_CFG:  cfg_q  <= reg_wdata[7:0];
                    default: ;
                endcase
            end
            if (launch) begin
                ctrl_q <= reg_wdata;
                busy_q <= 1'b1;
                err_q  <= reg_wdata[B_RD] & reg_wdata[B_WR];
                ce_n_q <= 1'b0;
            end
            if (cap) data_q[{bidx_q, 3'b000} +: 8] <= nand_dq_i;
            if (busy_q && ph_q == PH_DONE) begin
                busy_q <= 1'b0;
                ce_n_q <= ~ctrl_q[B_HOLD];
            end
            ph_q   <= ph_d;
            sub_q  <= sub_d;
            bidx_q <= bidx_d;
        end
    end

    assign stat_rdata = {busy_q, ctrl_q[30:28], err_q, ready_s, ctrl_q[25:0]};
    assign data_rdata = data_q;
    assign nand_ce_n  = ce_n_q;
    assign nand_cle   = (ph_q == PH_CMDA) || (ph_q == PH_CMDB);
    assign nand_ale   = ph_q inside {PH_SPEC, PH_COLA, PH_ROWA};
    assign nand_we_n  = !((sub_q == SB_LOW) && drv_phase);
    assign nand_re_n  = !((sub_q == SB_LOW) && rd_phase);
    assign nand_dq_oe = drv_phase;
    assign nand_dq_o  = drv_phase ? cur_byte : 8'h00;
endmodule

// File: rtl/nand_seq_chk.sv
// Protocol checker for the NAND sequencer, bound into every instance.
module nand_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic [31:0] ctrl,
    input logic        ce_n,
    input logic        cle,
    input logic        ale,
    input logic        we_n,
    input logic        re_n,
    input logic        dq_oe
);
    a_r3_latch_excl: assert property (@(posedge clk) disable iff (!rst_n) !(cle && ale));
    a_r11_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n) !(!we_n && !re_n));
    a_r9_ce_busy: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !ce_n);
    a_r9_ce_release: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !ctrl[30]) |-> ce_n);
    a_r10_ctrl_frozen: assert property (@(posedge clk) disable iff (!rst_n) busy |=> $stable(ctrl));
    a_r8_bus_free: assert property (@(posedge clk) disable iff (!rst_n) !re_n |-> !dq_oe);
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (we_n && re_n && !cle && !ale));
endmodule

bind nand_seq nand_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy_q), .ctrl(ctrl_q), .ce_n(nand_ce_n),
    .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n), .dq_oe(nand_dq_oe)
);

// File: tb/tb_nand_seq.sv
module tb_nand_seq;
    localparam int CLK_P = 10;

    logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, rb_n = 1'b1;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] stat_rdata, data_rdata;
    logic ce_n, cle, ale, we_n, re_n, dq_oe;
    logic [7:0] dq_o, dq_i, rd_base = 8'h5A;

    int n_chk = 0, n_fail = 0;
    int cyc = 0, ev_n = 0, rd_idx = 0, we_cnt = 0, re_cnt = 0;
    int bad_we = 0, bad_re = 0, exp_we = 2, exp_re = 3, last_rise = 0, exp_n = 0;
    logic [9:0] ev [0:31];
    logic [9:0] ex [0:31];
    logic w_cle, w_ale;
    logic [7:0] w_dq;

    always #(CLK_P/2) clk = ~clk;
    assign dq_i = rd_base + 8'(rd_idx);

    nand_seq dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .stat_rdata(stat_rdata), .data_rdata(data_rdata), .nand_ce_n(ce_n), .nand_cle(cle),
        .nand_ale(ale), .nand_we_n(we_n), .nand_re_n(re_n), .nand_dq_o(dq_o),
        .nand_dq_oe(dq_oe), .nand_dq_i(dq_i), .nand_rb_n(rb_n)
    );

    // Flash-side monitor: logs each write strobe and measures strobe widths.
    always @(negedge clk) begin
        cyc++;
        if (!we_n) begin
            we_cnt++; w_cle = cle; w_ale = ale; w_dq = dq_o;
        end else if (we_cnt != 0) begin
            if (ev_n < 32) ev[ev_n] = {w_cle, w_ale, w_dq};
            ev_n++;
            if (we_cnt != exp_we) bad_we++;
            we_cnt = 0;
            last_rise = cyc;
        end
        if (!re_n) re_cnt++;
        else if (re_cnt != 0) begin
            if (re_cnt != exp_re) bad_re++;
            re_cnt = 0;
            rd_idx++;
        end
    end

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic clear_log();
        ev_n = 0; rd_idx = 0; bad_we = 0; bad_re = 0; exp_n = 0;
    endtask

    task automatic wait_idle(output int done_at);
        int t;
        t = 0;
        while (stat_rdata[31] && t < 5000) begin @(negedge clk); t++; end
        done_at = cyc;
    endtask

    task automatic push(input logic [1:0] kind, input logic [7:0] v);
        ex[exp_n] = {kind, v}; exp_n++;
    endtask

    task automatic seq_chk(input string req);
        bit ok;
        int at;
        ok = (ev_n == exp_n);
        at = -1;
        for (int i = 0; i < exp_n && i < ev_n; i++) if (ok && ev[i] != ex[i]) begin ok = 0; at = i; end
        if (at < 0) chk(ok, req, 64'(ev_n), 64'(exp_n));
        else        chk(ok, req, 64'(ev[at]), 64'(ex[at]));
    endtask

    initial begin
        int done_at;
        logic [31:0] c, col, row, dat;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(stat_rdata[31] == 1'b0, "R1 busy", 64'(stat_rdata[31]), 0);
        chk({ce_n, we_n, re_n} == 3'b111, "R1 strobes", 64'({ce_n, we_n, re_n}), 64'h7);
        chk({cle, ale, dq_oe} == 3'b000, "R1 latches", 64'({cle, ale, dq_oe}), 0);
        chk(stat_rdata[26] == 1'b1, "R1 ready", 64'(stat_rdata[26]), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk({ce_n, we_n, re_n, cle, ale} == 5'b11100, "R1 after release", 64'({ce_n, we_n, re_n, cle, ale}), 64'h1C);

        // timing: we=2 re=3 setup=1 hold=1 long=8
        wr(3'd4, (32'd8 << 24) | (32'd1 << 18) | (32'd1 << 12) | (32'd3 << 6) | 32'd2);

        // R2: empty launch
        clear_log();
        wr(3'd0, 32'h8000_0000);
        chk(stat_rdata[31] == 1'b1, "R2 busy set", 64'(stat_rdata[31]), 1);
        wait_idle(done_at);
        chk(stat_rdata[31] == 1'b0 && ev_n == 0, "R2 empty step", 64'(ev_n), 0);

        // R3 R4 R6 R7 R11: sweep column/row byte counts and data counts
        for (int nc = 0; nc < 4; nc++) begin
            for (int nr = 0; nr < 4; nr++) begin
                int cnt;
                cnt = (nc + nr) % 4;
                col = 32'h1122_3344 ^ {4{8'(nc * 16 + nr)}};
                row = 32'h5566_7788 + 32'(nc * 4 + nr);
                dat = 32'hC3C2_C1C0 ^ {4{8'(nr * 16 + nc)}};
                wr(3'd5, 32'((nr << 6) | (nc << 4)));
                wr(3'd1, col); wr(3'd2, row); wr(3'd3, dat);
                clear_log();
                push(2'b10, 8'h80);
                for (int k = 0; k <= nc; k++) push(2'b01, col[8*k +: 8]);
                for (int k = 0; k <= nr; k++) push(2'b01, row[8*k +: 8]);
                push(2'b10, 8'h10);
                for (int k = 0; k <= cnt; k++) push(2'b00, dat[8*k +: 8]);
                c = 32'h8000_0000 | (32'(cnt) << 28) | 32'h0020_0000 | 32'h000F_0000 | 32'h0000_1080;
                wr(3'd0, c);
                wait_idle(done_at);
                seq_chk("R3/R4/R6/R7 sequence");
                chk(bad_we == 0, "R11 write strobe width", 64'(bad_we), 0);
                chk(ce_n == 1'b1, "R9 release", 64'(ce_n), 1);
            end
        end

        // R8: read two bytes, upper bytes retained
        wr(3'd5, 32'((2 << 6) | (1 << 4)));
        wr(3'd3, 32'hDEAD_BEEF);
        clear_log();
        wr(3'd0, 32'h8000_0000 | (32'd1 << 28) | 32'h0010_0000 | 32'h0007_0000 | 32'h0008_0000 | 32'h0000_3000);
        wait_idle(done_at);
        chk(data_rdata == 32'hDEAD_5B5A, "R8 two-byte read", 64'(data_rdata), 64'hDEAD_5B5A);
        chk(bad_re == 0 && rd_idx == 2, "R8/R11 read strobes", 64'(rd_idx), 2);

        // R8: four bytes
        clear_log();
        wr(3'd0, 32'h8000_0000 | (32'd3 << 28) | 32'h0010_0000 | 32'h0001_0000);
        wait_idle(done_at);
        chk(data_rdata == 32'h5D5C_5B5A, "R8 four-byte read", 64'(data_rdata), 64'h5D5C_5B5A);

        // R5 R9: special address with chip-enable hold
        wr(3'd5, 32'hF0);
        clear_log();
        push(2'b10, 8'h90); push(2'b01, 8'h00);
        wr(3'd0, 32'h8000_0000 | 32'h4000_0000 | 32'h0100_0000 | 32'h0007_0000 | 32'h0000_0090);
        wait_idle(done_at);
        seq_chk("R5 special address");
        chk(ce_n == 1'b0, "R9 hold after step", 64'(ce_n), 0);
        repeat (3) @(negedge clk);
        chk(ce_n == 1'b0, "R9 hold while idle", 64'(ce_n), 0);
        clear_log();
        push(2'b10, 8'hFF);
        wr(3'd0, 32'h8001_00FF);
        wait_idle(done_at);
        seq_chk("R9 reset command");
        chk(ce_n == 1'b1, "R9 release after clear", 64'(ce_n), 1);

        // R10 R12: ignored control write during a step with long wait
        clear_log();
        push(2'b10, 8'h70); push(2'b10, 8'hE0);
        wr(3'd0, 32'h8009_E070);
        wr(3'd0, 32'h8001_0011);
        wait_idle(done_at);
        seq_chk("R10 ignored write");
        chk(stat_rdata[15:0] == 16'hE070, "R10 control kept", 64'(stat_rdata[15:0]), 64'hE070);
        chk((done_at - last_rise) >= 9 && (done_at - last_rise) <= 13, "R12 long wait",
            64'(done_at - last_rise), 10);

        // R11: zero write-strobe field acts as one cycle
        wr(3'd4, (32'd8 << 24) | (32'd1 << 18) | (32'd1 << 12) | (32'd3 << 6));
        exp_we = 1;
        clear_log();
        wr(3'd0, 32'h8001_0055);
        wait_idle(done_at);
        chk(bad_we == 0 && ev_n == 1, "R11 zero width", 64'(bad_we), 0);

        // R13: error on read and write together, cleared by next launch
        clear_log();
        wr(3'd0, 32'h8031_0055);
        wait_idle(done_at);
        chk(stat_rdata[27] == 1'b1, "R13 error flag", 64'(stat_rdata[27]), 1);
        chk(ev_n == 1 && rd_idx == 0, "R13 no data cycles", 64'(ev_n), 1);
        clear_log();
        wr(3'd0, 32'h8001_0055);
        wait_idle(done_at);
        chk(stat_rdata[27] == 1'b0, "R13 error cleared", 64'(stat_rdata[27]), 0);

        // R13: ready mirror latency
        @(negedge clk); rb_n = 1'b0;
        @(negedge clk);
        chk(stat_rdata[26] == 1'b1, "R13 ready one edge", 64'(stat_rdata[26]), 1);
        @(negedge clk);
        chk(stat_rdata[26] == 1'b0, "R13 ready two edges", 64'(stat_rdata[26]), 0);
        rb_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(stat_rdata[26] == 1'b1, "R13 ready back", 64'(stat_rdata[26]), 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule